// File: doc/BRIEF.md
# Selectable-Width Condition Code Generator

This block turns the result of a 36-bit arithmetic unit into a set of stored status flags and a vector of branch-condition outcomes. The result is a 32-bit value with 4 guard bits stacked above it. A mode register chooses where carry, sign, overflow and zero are detected. In wide mode they are taken at bit 35, the top of the guard bits. In narrow mode they are taken at bit 31, the top of the 32-bit value. The extension flag, the unnormalized flag and the sticky limit flag are computed the same way in both modes.

The arithmetic unit supplies two carry-outs and two overflow indications, one for each boundary. Each cycle in which the update strobe is high, the flag register captures a new set of flags. Branch logic reads the condition vector, which is decoded from the stored flags. It covers unsigned compares and tests on zero and sign. The unsigned compares are only meaningful when the flags were produced in narrow mode. After reset the mode is wide and all flags are clear.

Top module: `ccg_top`

## Requirements
- R1: After reset, `flags_q` is all zero, `cond_true` is 8'h55, and the mode is wide (36-bit).
- R2: In wide mode an update sets N = `alu_res[35]`, Z = 1 exactly when all 36 result bits are zero, C = `carry_hi` and V = `ovf_hi`.
- R3: In narrow mode an update sets N = `alu_res[31]`, Z = 1 exactly when `alu_res[31:0]` is zero, C = `carry_lo` and V = `ovf_lo`.
- R4: On every update, E = 1 exactly when `alu_res[35:31]` is neither all zeros nor all ones, in either mode.
- R5: On every update, U = 1 exactly when `alu_res[31]` equals `alu_res[30]`, in either mode.
- R6: `flags_q` changes only on the clock edge where `upd_en` is high. When `upd_en` and `lim_clr` are both low, every flag holds, whatever the result inputs do. The field positions are bit0 C, bit1 V, bit2 Z, bit3 N, bit4 U, bit5 E, bit6 L.
- R7: L becomes 1 at any update whose new V is 1, and otherwise keeps its value. `lim_clr` clears L. If a clear and a setting update fall on the same edge, L ends up 1.
- R8: `cond_true` is decoded combinationally from `flags_q` as follows: bit0 HS = !C, bit1 LO = C, bit2 HI = !C & !Z, bit3 LS = C | Z, bit4 NE = !Z, bit5 EQ = Z, bit6 PL = !N, bit7 MI = N.
- R9: A mode write (`mode_we` high, `mode_narrow_d` giving the new mode, 1 = narrow) takes effect on the clock edge where it is sampled. An update sampled on that same edge still uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_res | input | 36 | Arithmetic result: guard bits [35:32] over value [31:0] |
| carry_lo | input | 1 | Carry out of bit 31 |
| carry_hi | input | 1 | Carry out of bit 35 |
| ovf_lo | input | 1 | Overflow at the 32-bit boundary |
| ovf_hi | input | 1 | Overflow at the 36-bit boundary |
| upd_en | input | 1 | Capture new flags on this edge |
| lim_clr | input | 1 | Clear the sticky limit flag |
| mode_we | input | 1 | Write the mode register |
| mode_narrow_d | input | 1 | New mode value, 1 = 32-bit detection |
| flags_q | output | 7 | Stored flags {L,E,U,N,Z,V,C} |
| cond_true | output | 8 | Branch condition outcomes, one per code |

## Verification
A wrong mode register would not show up right away. It surfaces on the next update whose result differs between the two boundaries: set guard bits with a zero low word, or carries that disagree. Those inputs give the wrong C, Z or N one cycle after the strobe. A corrupted L flag stays wrong until a clear arrives, so it is caught on the first update after the fault. Because `cond_true` is decoded from `flags_q` with no further register, any flag error reaches the condition vector in that same cycle. The sweeps cover every combination of the six top result bits in both modes, so a wrong boundary selection cannot escape.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
   localparam int FLAG_W = 7;
   localparam int F_C = 0;
   localparam int F_V = 1;
   localparam int F_Z = 2;
   localparam int F_N = 3;
   localparam int F_U = 4;
   localparam int F_E = 5;
   localparam int F_L = 6;
   localparam int COND_W = 8;

   typedef struct packed {
      logic e;
      logic u;
      logic n;
      logic z;
      logic v;
      logic c;
   } fresh_t;
endpackage

// File: rtl/ccg_flag_eval.sv
module ccg_flag_eval
   import ccg_pkg::*;
#(
   parameter int LOW_W = 32,
   parameter int EXT_W = 4,
   localparam int RES_W = LOW_W + EXT_W
) (
   input  logic [RES_W-1:0] res,
   input  logic             carry_lo,
   input  logic             carry_hi,
   input  logic             ovf_lo,
   input  logic             ovf_hi,
   input  logic             narrow,
   output fresh_t           fresh
);
   localparam int TOP_W = EXT_W + 1;

   initial begin
      assert (LOW_W >= 2) else $error("LOW_W must be at least 2");
      assert (EXT_W >= 1) else $error("EXT_W must be at least 1");
   end

   logic zero_lo, zero_all;
   logic [TOP_W-1:0] top_bits;

   assign zero_lo  = ~|res[LOW_W-1:0];
   assign zero_all = zero_lo & ~|res[RES_W-1:LOW_W];
   assign top_bits = res[RES_W-1:LOW_W-1];

   always_comb begin
      fresh.c = narrow ? carry_lo : carry_hi;
      fresh.v = narrow ? ovf_lo : ovf_hi;
      fresh.n = narrow ? res[LOW_W-1] : res[RES_W-1];
      fresh.z = narrow ? zero_lo : zero_all;
      fresh.e = ~((&top_bits) | ~(|top_bits));
      fresh.u = ~(res[LOW_W-1] ^ res[LOW_W-2]);
   end
endmodule

// File: rtl/ccg_flag_reg.sv
module ccg_flag_reg
   import ccg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              lim_clr,
   input  fresh_t            fresh,
   output logic [FLAG_W-1:0] flags_q
);
   logic lim_set;
   assign lim_set = upd & fresh.v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         if (upd) begin
            flags_q[F_C] <= fresh.c;
            flags_q[F_V] <= fresh.v;
            flags_q[F_Z] <= fresh.z;
            flags_q[F_N] <= fresh.n;
            flags_q[F_U] <= fresh.u;
            flags_q[F_E] <= fresh.e;
         end
         flags_q[F_L] <= (flags_q[F_L] & ~lim_clr) | lim_set;
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !lim_clr) |=> $stable(flags_q));

   assert_lim_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && fresh.v) |=> flags_q[F_L]);

   assert_lim_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_clr && !(upd && fresh.v)) |=> !flags_q[F_L]);
endmodule

// File: rtl/ccg_cond_eval.sv
module ccg_cond_eval
   import ccg_pkg::*;
(
   input  logic [FLAG_W-1:0] flags,
   output logic [COND_W-1:0] cond
);
   localparam int PAIRS = COND_W / 2;

   logic [PAIRS-1:0] base;

   always_comb begin
      base[0] = ~flags[F_C];
      base[1] = ~flags[F_C] & ~flags[F_Z];
      base[2] = ~flags[F_Z];
      base[3] = ~flags[F_N];
   end

   for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      assign cond[2*i]   = base[i];
      assign cond[2*i+1] = ~base[i];
   end
endmodule

// File: rtl/ccg_top.sv
module ccg_top
   import ccg_pkg::*;
#(
   parameter int LOW_W = 32,
   parameter int EXT_W = 4,
   localparam int RES_W = LOW_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RES_W-1:0]  alu_res,
   input  logic              carry_lo,
   input  logic              carry_hi,
   input  logic              ovf_lo,
   input  logic              ovf_hi,
   input  logic              upd_en,
   input  logic              lim_clr,
   input  logic              mode_we,
   input  logic              mode_narrow_d,
   output logic [FLAG_W-1:0] flags_q,
   output logic [COND_W-1:0] cond_true
);
   logic   narrow_q;
   fresh_t fresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       narrow_q <= 1'b0;
      else if (mode_we) narrow_q <= mode_narrow_d;
   end

   ccg_flag_eval #(.LOW_W(LOW_W), .EXT_W(EXT_W)) u_eval (
      .res(alu_res), .carry_lo(carry_lo), .carry_hi(carry_hi),
      .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .narrow(narrow_q), .fresh(fresh)
   );

   ccg_flag_reg u_reg (
      .clk(clk), .rst_n(rst_n), .upd(upd_en), .lim_clr(lim_clr),
      .fresh(fresh), .flags_q(flags_q)
   );

   ccg_cond_eval u_cond (.flags(flags_q), .cond(cond_true));

   // Zero across the selected width includes the selected sign bit (R2, R3)
   assert_zero_excl_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags_q[F_Z] && flags_q[F_N]));

   assert_lo_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cond_true[1] == flags_q[F_C]);

   assert_capture_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !narrow_q) |=> flags_q[F_C] == $past(carry_hi));
endmodule

// File: tb/ccg_top_bench.sv
module ccg_top_bench;
   localparam int RW = 36;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [RW-1:0] alu_res = '0;
   logic          carry_lo = 0, carry_hi = 0, ovf_lo = 0, ovf_hi = 0;
   logic          upd_en = 0, lim_clr = 0, mode_we = 0, mode_narrow_d = 0;
   logic [6:0]    flags_q;
   logic [7:0]    cond_true;

   int n_chk = 0;
   int n_bad = 0;
   logic m_narrow = 0;
   logic m_lim = 0;

   always #10 clk = ~clk;

   ccg_top u_ccg_top (
      .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .carry_lo(carry_lo),
      .carry_hi(carry_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .upd_en(upd_en),
      .lim_clr(lim_clr), .mode_we(mode_we), .mode_narrow_d(mode_narrow_d),
      .flags_q(flags_q), .cond_true(cond_true)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] cond_of(input logic [6:0] f);
      logic c, z, n;
      c = f[0]; z = f[2]; n = f[3];
      return {n, ~n, z, ~z, c | z, ~c & ~z, c, ~c};
   endfunction

   function automatic logic [6:0] model(input logic [RW-1:0] r, input logic cl, input logic ch,
                                         input logic ol, input logic oh, input logic nar,
                                         input logic lim);
      logic c, v, z, n, e, u;
      c = nar ? cl : ch;
      v = nar ? ol : oh;
      n = nar ? r[31] : r[35];
      z = nar ? (r[31:0] == 0) : (r == 0);
      e = !((r[35:31] == 5'h00) || (r[35:31] == 5'h1f));
      u = (r[31] == r[30]);
      return {lim | v, e, u, n, z, v, c};
   endfunction

   task automatic apply(input string req, input logic [RW-1:0] r, input logic cl, input logic ch,
                        input logic ol, input logic oh);
      logic [6:0] exp;
      @(negedge clk);
      alu_res = r; carry_lo = cl; carry_hi = ch; ovf_lo = ol; ovf_hi = oh; upd_en = 1;
      exp = model(r, cl, ch, ol, oh, m_narrow, m_lim);
      m_lim = exp[6];
      @(negedge clk);
      upd_en = 0;
      check(req, {1'b0, flags_q}, {1'b0, exp});
      check("R8", cond_true, cond_of(exp));
   endtask

   task automatic set_mode(input logic nar);
      @(negedge clk);
      mode_we = 1; mode_narrow_d = nar;
      @(negedge clk);
      mode_we = 0;
      m_narrow = nar;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [6:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1", {1'b0, flags_q}, 8'h00);
      check("R1", cond_true, 8'h55);
      // R1: default mode is wide: guard bit set, low word zero, hi carry only
      apply("R1", 36'h1_0000_0000, 0, 1, 0, 0);

      // Sweep top six bits, two low-word shapes, both modes (R2..R5, R8)
      for (int md = 0; md < 2; md++) begin
         set_mode(md[0]);
         for (int hi = 0; hi < 64; hi++) begin
            for (int lw = 0; lw < 2; lw++) begin
               logic [RW-1:0] r;
               r = {hi[5:0], (lw == 0) ? 30'd0 : (30'd1 << (hi % 30))};
               apply(md == 0 ? "R2/R4/R5" : "R3/R4/R5", r,
                     hi[0] ^ lw[0], hi[1], hi[2] & ~lw[0], hi[3] ^ hi[4]);
            end
         end
      end

      // R6: hold while strobe is low
      @(negedge clk);
      held = flags_q;
      alu_res = 36'hF_FFFF_FFFF; carry_lo = 1; carry_hi = 1; ovf_lo = 1; ovf_hi = 1;
      repeat (4) @(negedge clk);
      check("R6", {1'b0, flags_q}, {1'b0, held});

      // R7: clear, then same-edge clear and set
      @(negedge clk); lim_clr = 1;
      @(negedge clk); lim_clr = 0; m_lim = 0;
      check("R7", {7'b0, flags_q[6]}, 8'h00);
      @(negedge clk);
      lim_clr = 1; upd_en = 1; alu_res = 36'h0_4000_0000; ovf_lo = 1; ovf_hi = 1;
      @(negedge clk);
      lim_clr = 0; upd_en = 0;
      check("R7", {7'b0, flags_q[6]}, 8'h01);
      m_lim = 1;
      apply("R7", 36'h0_4000_0000, 0, 0, 0, 0);

      // R9: mode write and update on the same edge use the old mode (narrow -> wide)
      @(negedge clk);
      mode_we = 1; mode_narrow_d = 0; upd_en = 1;
      alu_res = 36'h1_0000_0000; carry_lo = 1; carry_hi = 0; ovf_lo = 0; ovf_hi = 0;
      @(negedge clk);
      mode_we = 0; upd_en = 0;
      check("R9", {1'b0, flags_q}, {1'b0, model(36'h1_0000_0000, 1, 0, 0, 0, 1, m_lim)});
      m_narrow = 0;
      apply("R9", 36'h1_0000_0000, 1, 0, 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule